// File: doc/BRIEF.md
# Stacked-Carrier Five-Level PWM Modulator

This block produces the gate commands for a three-phase inverter in which every phase is built from two H-bridge cells wired in series. Each cell has four switches. A cell can add a positive step, add a negative step, or add nothing to the phase voltage. With two cells per phase, the phase takes one of five levels, from -2 to +2 steps.

Four triangular carriers are stacked one above the other in adjacent amplitude bands, and all of them rise and fall together. A sinusoidal reference for each phase is read from a shared sine table, with the three phases spaced a third of the table apart. The reference is scaled by a modulation-index word and compared against every carrier. The number of carriers it lies strictly above, minus two, gives the phase level. That level is then turned into four-switch patterns for the two cells and registered onto 24 gate outputs.

Two prescale inputs set the carrier and reference rates. The designer chooses them for the target frequencies, for example a 1 kHz carrier and a 50 Hz reference, and an index of about 0.8 is typical.

Top module: `lspwm_modulator`

## Requirements
- R1: While `rst` is high, every cell drives the zero pattern 4'b0011, so `gates_o` reads 24'h333333 one clock edge after reset is seen.
- R2: While `en` is low, the next clock edge puts every cell into the zero pattern 4'b0011, whatever the index word is. The carrier and reference counters are held at zero while `en` is low.
- R3: A cell occupies 4 bits of `gates_o`. Bit 0 drives switch 1, bit 1 switch 2, bit 2 switch 3 and bit 3 switch 4. The patterns are: positive step 4'b1001, negative step 4'b0110, zero 4'b0011. Phase p (0 = A, 1 = B, 2 = C) uses bits [8p+3:8p] for its upper cell and bits [8p+7:8p+4] for its lower cell.
- R4: Levels map onto the cells as follows:
  - +2: both cells positive.
  - +1: upper cell positive, lower cell zero.
  - 0: both cells zero.
  - -1: upper cell negative, lower cell zero.
  - -2: both cells negative.
- R5: Switches 1 and 3 of a cell are never on together, and neither are switches 2 and 4. Any such pattern is replaced by the zero pattern 4'b0011.
- R6: The phase level is the count of carriers that the reference strictly exceeds, minus 2. A reference equal to a carrier does not count. With the reference at mid-scale, the level is -1 only while the triangle sits at its peak; at every other moment it is 0.
- R7: Each carrier band is W = 16 counts wide. The triangle moves one count every `car_div`+1 clocks, running 0 up to W and back down, so one carrier period is 2·W·(`car_div`+1) clocks.
- R8: The reference equals mid-scale plus (sine·`mod_idx`)/256, with a sine peak of 2W. An index of 0 gives a flat mid-scale reference. An index of 128 never produces level +2. An index of 255 reaches both +2 and -2.
- R9: The sine table has 96 entries, and each entry lasts `ref_div`+1 clocks. Phase B lags phase A by one third of the reference period, and phase C lags phase A by two thirds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces every cell to the zero pattern |
| mod_idx | input | 8 | Modulation index, unsigned fraction of 256 |
| car_div | input | 16 | Carrier step prescale; one triangle step every car_div+1 clocks |
| ref_div | input | 16 | Reference step prescale; one table step every ref_div+1 clocks |
| gates_o | output | 24 | Registered gate commands, 4 per cell, 2 cells per phase, 3 phases |

## Verification
The tie rule and the triangle reversal fall in the same cycle. When the index is zero, the reference sits exactly on the second carrier at the moment the triangle reaches its peak and turns around. That is the only time the level leaves 0, so a wrong tie rule or a wrong peak dwell changes the result. The bench sets a zero index at two carrier prescales and counts the -1 cycles of every phase over a whole number of carrier periods. It expects exactly one peak dwell of `car_div`+1 cycles per period. A full-index run also compares the recorded level streams of phases B and C with phase A, shifted by one and two thirds of the reference period.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;
  typedef logic [3:0] cell_gate_t;

  // bit0 = switch 1 ... bit3 = switch 4
  localparam cell_gate_t CELL_POS  = 4'b1001;
  localparam cell_gate_t CELL_NEG  = 4'b0110;
  localparam cell_gate_t CELL_ZERO = 4'b0011;

  // Replace shoot-through combinations by the switch-1/2 zero state.
  function automatic cell_gate_t cell_guard(input cell_gate_t g);
    if ((g[0] && g[2]) || (g[1] && g[3])) return CELL_ZERO;
    return g;
  endfunction

  // Cell c (0 = upper) of a series stack for a signed level.
  function automatic cell_gate_t cell_for_level(input int lvl, input int c);
    if (lvl > c)  return CELL_POS;
    if (lvl < -c) return CELL_NEG;
    return CELL_ZERO;
  endfunction
endpackage

// File: rtl/lspwm_carrier.sv
module lspwm_carrier #(
  parameter int CBW = 4,
  parameter int PSW = 16,
  localparam int W  = 1 << CBW,
  localparam int TW = CBW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [PSW-1:0] div_i,
  output logic [TW-1:0]  tri_o
);
  logic [PSW-1:0] div_cnt;
  logic [TW-1:0]  tri_q;
  logic           down_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_cnt <= '0;
      tri_q   <= '0;
      down_q  <= 1'b0;
    end else if (div_cnt >= div_i) begin
      div_cnt <= '0;
      if (!down_q) begin
        tri_q <= tri_q + 1'b1;
        if (tri_q == TW'(W - 1)) down_q <= 1'b1;
      end else begin
        tri_q <= tri_q - 1'b1;
        if (tri_q == TW'(1)) down_q <= 1'b0;
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign tri_o = tri_q;

  a_r7_tri_bounded: assert property (@(posedge clk) disable iff (rst)
    tri_q <= TW'(W));
  a_r7_tri_step: assert property (@(posedge clk) disable iff (rst)
    (en && tri_q != $past(tri_q)) |->
      (tri_q == $past(tri_q) + 1'b1 || tri_q + 1'b1 == $past(tri_q)));
endmodule

// File: rtl/lspwm_reference.sv
module lspwm_reference #(
  parameter int CBW     = 4,
  parameter int NCELL   = 2,
  parameter int NPH     = 3,
  parameter int TBL_LEN = 96,
  parameter int MW      = 8,
  parameter int PSW     = 16,
  localparam int W      = 1 << CBW,
  localparam int AW     = CBW + $clog2(2 * NCELL) + 1,
  localparam int SW     = AW + 1,
  localparam int IW     = $clog2(TBL_LEN),
  localparam int AMP    = NCELL * W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PSW-1:0]          div_i,
  input  logic [MW-1:0]           mod_idx,
  output logic [NPH-1:0][AW-1:0]  ref_o
);
  localparam logic signed [SW+MW:0] MID_S = (SW+MW+1)'(AMP);

  // Integer half-wave sine approximation, peak AMP at quarter points.
  function automatic int sine_pt(input int i);
    int h, q, num, den, v;
    h   = TBL_LEN / 2;
    q   = i % h;
    num = 16 * q * (h - q);
    den = 5 * h * h - 4 * q * (h - q);
    v   = (AMP * num) / den;
    return (i < h) ? v : -v;
  endfunction

  logic signed [SW-1:0] sine_rom [TBL_LEN];
  initial begin
    for (int i = 0; i < TBL_LEN; i++) sine_rom[i] = SW'(sine_pt(i));
  end

  logic [PSW-1:0] div_cnt;
  logic [IW-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_cnt <= '0;
      idx_q   <= '0;
    end else if (div_cnt >= div_i) begin
      div_cnt <= '0;
      idx_q   <= (idx_q == IW'(TBL_LEN - 1)) ? '0 : idx_q + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    localparam int OFF = ((NPH - p) % NPH) * TBL_LEN / NPH;
    logic [IW-1:0]          pidx;
    logic signed [SW-1:0]   samp_q;
    logic signed [SW+MW:0]  prod;

    assign pidx = IW'((int'(idx_q) + OFF) % TBL_LEN);
    always_ff @(posedge clk) samp_q <= sine_rom[pidx];
    assign prod     = samp_q * $signed({1'b0, mod_idx});
    assign ref_o[p] = AW'(MID_S + (prod >>> MW));
  end

  a_r9_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx_q < IW'(TBL_LEN));
endmodule

// File: rtl/lspwm_phase_slicer.sv
module lspwm_phase_slicer
  import lspwm_pkg::*;
#(
  parameter int CBW   = 4,
  parameter int NCELL = 2,
  localparam int W    = 1 << CBW,
  localparam int NCAR = 2 * NCELL,
  localparam int AW   = CBW + $clog2(NCAR) + 1,
  localparam int TW   = CBW + 1,
  localparam int GW   = 4 * NCELL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] ref_i,
  input  logic [TW-1:0] tri_i,
  output logic [GW-1:0] gate_o
);
  logic [NCAR-1:0] above;
  logic [GW-1:0]   gate_d, gate_q;
  int              lvl;

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    assign above[k] = ref_i > (AW'(k * W) + AW'(tri_i));
  end

  assign lvl = $countones(above) - NCELL;

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    assign gate_d[c*4 +: 4] = cell_guard(cell_for_level(lvl, c));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) gate_q <= {NCELL{CELL_ZERO}};
    else            gate_q <= gate_d;
  end

  assign gate_o = gate_q;

  for (genvar c = 0; c < NCELL; c++) begin : g_chk
    a_r5_no_shoot: assert property (@(posedge clk) disable iff (rst)
      !((gate_q[c*4] && gate_q[c*4+2]) || (gate_q[c*4+1] && gate_q[c*4+3])));
    if (c > 0) begin : g_agree
      a_r4_cells_agree: assert property (@(posedge clk) disable iff (rst)
        (gate_q[c*4 +: 4] != CELL_ZERO) |-> (gate_q[(c-1)*4 +: 4] == gate_q[c*4 +: 4]));
    end
  end

  a_r6_floor_ref: assert property (@(posedge clk) disable iff (rst)
    (en && ref_i == '0) |=> (gate_q == {NCELL{CELL_NEG}}));
endmodule

// File: rtl/lspwm_modulator.sv
module lspwm_modulator
  import lspwm_pkg::*;
#(
  parameter int CBW     = 4,
  parameter int NCELL   = 2,
  parameter int NPH     = 3,
  parameter int TBL_LEN = 96,
  parameter int MW      = 8,
  parameter int PSW     = 16,
  localparam int NCAR   = 2 * NCELL,
  localparam int AW     = CBW + $clog2(NCAR) + 1,
  localparam int TW     = CBW + 1,
  localparam int GW     = 4 * NCELL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [MW-1:0]     mod_idx,
  input  logic [PSW-1:0]    car_div,
  input  logic [PSW-1:0]    ref_div,
  output logic [NPH*GW-1:0] gates_o
);
  logic [TW-1:0]          tri_w;
  logic [NPH-1:0][AW-1:0] ref_w;

  lspwm_carrier #(.CBW(CBW), .PSW(PSW)) u_carrier (
    .clk(clk), .rst(rst), .en(en), .div_i(car_div), .tri_o(tri_w)
  );

  lspwm_reference #(
    .CBW(CBW), .NCELL(NCELL), .NPH(NPH), .TBL_LEN(TBL_LEN), .MW(MW), .PSW(PSW)
  ) u_reference (
    .clk(clk), .rst(rst), .en(en), .div_i(ref_div), .mod_idx(mod_idx), .ref_o(ref_w)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_slice
    lspwm_phase_slicer #(.CBW(CBW), .NCELL(NCELL)) u_slicer (
      .clk(clk), .rst(rst), .en(en), .ref_i(ref_w[p]), .tri_i(tri_w),
      .gate_o(gates_o[p*GW +: GW])
    );
  end

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gates_o == {(NPH*NCELL){CELL_ZERO}}));
endmodule

// File: tb/lspwm_modulator_tb.sv
module lspwm_modulator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int NTAB = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [7:0]  mod_idx = '0;
  logic [15:0] car_div = '0;
  logic [15:0] ref_div = 16'd3;
  logic [23:0] gates_o;

  int checks = 0;
  int fails  = 0;
  int la [768];
  int lb [768];
  int lc [768];

  always #(CLK_PERIOD/2) clk = ~clk;

  lspwm_modulator u_dut (
    .clk(clk), .rst(rst), .en(en), .mod_idx(mod_idx),
    .car_div(car_div), .ref_div(ref_div), .gates_o(gates_o)
  );

  function automatic int decode(input logic [3:0] up, input logic [3:0] lo);
    if (up == 4'b1001 && lo == 4'b1001) return 2;
    if (up == 4'b1001 && lo == 4'b0011) return 1;
    if (up == 4'b0011 && lo == 4'b0011) return 0;
    if (up == 4'b0110 && lo == 4'b0011) return -1;
    if (up == 4'b0110 && lo == 4'b0110) return -2;
    return 99;
  endfunction

  function automatic int level_of(input int p);
    return decode(gates_o[8*p +: 4], gates_o[8*p+4 +: 4]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; en = 1'b1; mod_idx = 8'd255;
    wait_n(3);
    check(gates_o == 24'h333333, "R1 reset zero state", int'(gates_o), 24'h333333);
    rst = 1'b0;
  endtask

  // Flat reference: level -1 only at the triangle peak (tie at carrier 1).
  task automatic t_flat(input int pc);
    int neg [3];
    int other [3];
    int win;
    en = 1'b1; mod_idx = 8'd0; car_div = 16'(pc); ref_div = 16'd3;
    wait_n(20);
    for (int p = 0; p < 3; p++) begin neg[p] = 0; other[p] = 0; end
    win = 4 * 2 * W * (pc + 1);
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (level_of(p) == -1) neg[p]++;
        else if (level_of(p) != 0) other[p]++;
      end
    end
    for (int p = 0; p < 3; p++) begin
      check(neg[p] == 4 * (pc + 1), "R6 R7 peak tie dwell", neg[p], 4 * (pc + 1));
      check(other[p] == 0, "R3 R8 flat reference levels", other[p], 0);
    end
  endtask

  task automatic t_half;
    int plus2, plus1, bad;
    plus2 = 0; plus1 = 0; bad = 0;
    en = 1'b1; mod_idx = 8'd128; car_div = '0; ref_div = 16'd3;
    wait_n(20);
    for (int i = 0; i < 768; i++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (level_of(p) == 2) plus2++;
        if (level_of(p) == 1) plus1++;
        if (level_of(p) == 99) bad++;
      end
    end
    check(plus2 == 0, "R8 half index never +2", plus2, 0);
    check(plus1 > 0, "R8 half index reaches +1", plus1, 1);
    check(bad == 0, "R3 R5 legal cell patterns", bad, 0);
  endtask

  task automatic t_full;
    int hi, lo, bad, mb, mc;
    hi = 0; lo = 0; bad = 0; mb = 0; mc = 0;
    en = 1'b1; mod_idx = 8'd255; car_div = '0; ref_div = 16'd3;
    wait_n(20);
    for (int i = 0; i < 768; i++) begin
      @(negedge clk);
      la[i] = level_of(0); lb[i] = level_of(1); lc[i] = level_of(2);
      if (la[i] == 2) hi++;
      if (la[i] == -2) lo++;
      if (la[i] == 99 || lb[i] == 99 || lc[i] == 99) bad++;
    end
    check(hi > 0, "R8 full index reaches +2", hi, 1);
    check(lo > 0, "R8 full index reaches -2", lo, 1);
    check(bad == 0, "R4 R5 level to cell map", bad, 0);
    // one third of the period = 96*4/3 = 128 clocks
    for (int t = 0; t < 384; t++) begin
      if (lb[t + 128] != la[t]) mb++;
      if (lc[t + 256] != la[t]) mc++;
    end
    check(mb == 0, "R9 phase B lags A by a third", mb, 0);
    check(mc == 0, "R9 phase C lags A by two thirds", mc, 0);
  endtask

  task automatic t_idle;
    en = 1'b0; mod_idx = 8'd255;
    wait_n(2);
    check(gates_o == 24'h333333, "R2 enable low zero state", int'(gates_o), 24'h333333);
  endtask

  initial begin
    t_reset();
    t_flat(0);
    t_flat(2);
    t_half();
    t_full();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule